// File: doc/BRIEF.md
# DRAM Parallel Test Mode Logic

This block is the device-side control for a small dynamic memory with multiplexed addressing and a latched 2-bit parallel test mode. A fast system clock samples the active-low row strobe, column strobe and write strobe. Falling edges are found by comparing each sample with the one before. A row strobe fall with the column strobe high opens a row. Column strobe falls inside that row then do early writes or reads, and several of them can follow one another under a single open row.

A row strobe fall while the column strobe is already low is a refresh-type cycle. If the write strobe is also low at that moment, the device enters test mode, and the mode stays latched across any number of later cycles. Two cycles leave the mode: a refresh-type cycle with the write strobe high, or a row cycle that closes without any column strobe (a row-only refresh).

While the mode is active, column address bit 0 is ignored. A write stores the data word into both the even and the odd column of the selected pair. A read returns, on each data bit, a high level if the two stored bits agree and a low level if they differ. That result appears a configurable number of clock cycles later than a normal read.

Top module: `dram_ptest_core`

## Requirements
- R1: After reset, testmode_active is 0, dq_oe is 0, dq_out is 0 and every stored word reads back as 0.
- R2: In normal mode, a column strobe fall with we_n high inside an open row reads word {row, column}. From the cycle after the strobe is sampled, dq_oe is 1 and dq_out holds the word while oe_n is low and cas_n stays low.
- R3: A row strobe fall sampled while cas_n and we_n are both low sets testmode_active from the next cycle.
- R4: testmode_active keeps its value through row cycles that contain column accesses, and through every cycle that is neither an entry nor an exit.
- R5: A row strobe fall sampled while cas_n is low and we_n is high clears testmode_active from the next cycle, and it writes nothing to the array.
- R6: A row cycle (cas_n high at the row strobe fall) that closes with no column strobe fall clears testmode_active from the cycle after the row strobe rise is sampled.
- R7: In test mode, a column write stores dq_in into both column (c with bit 0 = 0) and column (c with bit 0 = 1) of the open row, whatever the value of column bit 0.
- R8: In test mode, a read returns dq_out bit i = 1 exactly when bit i of the even and odd words of the pair are equal. The result is the same for both values of column bit 0.
- R9: In test mode, dq_oe rises TM_EXTRA cycles (default 1) later than in normal mode after a read strobe.
- R10: A column strobe with we_n low (early write) never drives the outputs: dq_oe is 0 in the cycle after it.
- R11: Several column strobes under one open row each act on the row latched at the row strobe fall.
- R12: While oe_n is high, dq_oe is 0 and dq_out is 0. Lowering oe_n again during a read restores the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data or per-bit agreement flags; 0 when not driven |
| dq_oe | output | 1 | High while dq_out carries valid read data |
| testmode_active | output | 1 | Latched parallel test mode state |

## Verification
A wrongly latched mode bit shows up at the next read as an agreement pattern where a data word was expected, or the reverse. It also shows up one cycle earlier or later in when dq_oe rises, and testmode_active shows it directly one cycle after the faulty strobe edge. A bad pair write shows up only at the next normal read of the neighbouring column, so the bench reads both columns of a pair back after leaving the mode. The random phase mixes entries, both kinds of exit and page bursts, so a stale row latch or a misread refresh cycle turns into a data miscompare within a few strobe cycles.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  localparam int MAX_W = 32;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ROW     = 2'd1,
    PH_REFRESH = 2'd2
  } phase_e;

  // per-bit agreement of two words: 1 where they match
  function automatic logic [MAX_W-1:0] agree_mask(input logic [MAX_W-1:0] a,
                                                  input logic [MAX_W-1:0] b);
    return ~(a ^ b);
  endfunction

  // flat word index from row and column
  function automatic logic [MAX_W-1:0] word_index(input logic [MAX_W-1:0] row,
                                                  input logic [MAX_W-1:0] col,
                                                  input int col_w);
    return (row << col_w) | col;
  endfunction

endpackage

// File: rtl/dtm_strobe_decode.sv
module dtm_strobe_decode
  import dtm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] row_addr,
  output logic              wr_strobe,
  output logic              rd_strobe,
  output logic              tm_set,
  output logic              tm_clr_cbr,
  output logic              tm_clr_rowonly
);

  logic   ras_q, cas_q, col_seen;
  phase_e phase;

  logic ras_fall, ras_rise, cas_fall;
  logic cbr_cycle, row_start, col_strobe;

  assign ras_fall   = ras_q & ~ras_n;
  assign ras_rise   = ~ras_q & ras_n;
  assign cas_fall   = cas_q & ~cas_n;

  assign cbr_cycle  = ras_fall & ~cas_n;
  assign row_start  = ras_fall & cas_n;
  assign col_strobe = (phase == PH_ROW) & cas_fall & ~ras_n;

  assign wr_strobe      = col_strobe & ~we_n;
  assign rd_strobe      = col_strobe & we_n;
  assign tm_set         = cbr_cycle & ~we_n;
  assign tm_clr_cbr     = cbr_cycle & we_n;
  assign tm_clr_rowonly = ras_rise & (phase == PH_ROW) & ~col_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      phase    <= PH_IDLE;
      col_seen <= 1'b0;
      row_addr <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (row_start) begin
        phase    <= PH_ROW;
        col_seen <= 1'b0;
        row_addr <= addr;
      end else if (cbr_cycle) begin
        phase <= PH_REFRESH;
      end else if (ras_rise) begin
        phase <= PH_IDLE;
      end
      if (col_strobe) col_seen <= 1'b1;
    end
  end

  // R11: column accesses happen only while the row strobe is held low
  p_col_in_row_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe || rd_strobe) |-> (!ras_n && !ras_q));

  // R5: a refresh-type cycle never doubles as a column access
  p_cbr_no_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_set || tm_clr_cbr) |=> !(wr_strobe || rd_strobe));

endmodule

// File: rtl/dtm_mode_latch.sv
module dtm_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic tm_set,
  input  logic tm_clr_cbr,
  input  logic tm_clr_rowonly,
  output logic tm_q
);

  logic tm_clr;
  assign tm_clr = tm_clr_cbr | tm_clr_rowonly;

  always_ff @(posedge clk) begin
    if (!rst_n)      tm_q <= 1'b0;
    else if (tm_set) tm_q <= 1'b1;
    else if (tm_clr) tm_q <= 1'b0;
  end

  p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tm_set |=> tm_q);

  p_exit_cbr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tm_clr_cbr |=> !tm_q);

  p_exit_rowonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tm_clr_rowonly |=> !tm_q);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tm_set || tm_clr_cbr || tm_clr_rowonly) |=> $stable(tm_q));

endmodule

// File: rtl/dtm_array.sv
module dtm_array
  import dtm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] row,
  input  logic [ADDR_W-1:0] col,
  input  logic              wr_en,
  input  logic              wr_both,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_even,
  output logic [DW-1:0]     rd_odd
);

  localparam int IDX_W = 2 * ADDR_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]     mem [DEPTH];
  logic [IDX_W-1:0]  idx_even, idx_odd, idx_sel;
  logic [DEPTH-1:0]  word_we;

  assign idx_even = IDX_W'(word_index(MAX_W'(row), MAX_W'({col[ADDR_W-1:1], 1'b0}), ADDR_W));
  assign idx_odd  = IDX_W'(word_index(MAX_W'(row), MAX_W'({col[ADDR_W-1:1], 1'b1}), ADDR_W));
  assign idx_sel  = col[0] ? idx_odd : idx_even;

  assign rd_even = mem[idx_even];
  assign rd_odd  = mem[idx_odd];

  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign word_we[i] = wr_en &&
      ((IDX_W'(i) == idx_sel) ||
       (wr_both && ((IDX_W'(i) == idx_even) || (IDX_W'(i) == idx_odd))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++)
        if (word_we[k]) mem[k] <= wdata;
    end
  end

  // R7: a pair write leaves both words of the pair identical
  p_pair_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_both) |=> (mem[$past(idx_even)] == mem[$past(idx_odd)]));

  // R2: a single write lands exactly the written word
  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_both) |=> (mem[$past(idx_sel)] == $past(wdata)));

endmodule

// File: rtl/dtm_read_path.sv
module dtm_read_path
  import dtm_pkg::*;
#(
  parameter int DW       = 4,
  parameter int TM_EXTRA = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_strobe,
  input  logic          wr_strobe,
  input  logic          cas_n,
  input  logic          oe_n,
  input  logic          tm,
  input  logic          col_lsb,
  input  logic [DW-1:0] rd_even,
  input  logic [DW-1:0] rd_odd,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  localparam int WAIT_W = $clog2(TM_EXTRA + 2);

  logic [DW-1:0]     rd_data, next_data, cmp_flags;
  logic              rd_live;
  logic [WAIT_W-1:0] rd_wait;
  logic              rd_ready;

  assign cmp_flags = DW'(agree_mask(MAX_W'(rd_even), MAX_W'(rd_odd)));
  assign next_data = tm ? cmp_flags : (col_lsb ? rd_odd : rd_even);
  assign rd_ready  = rd_live && (rd_wait == '0);
  assign dq_oe     = rd_ready && !oe_n;
  assign dq_out    = dq_oe ? rd_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_live <= 1'b0;
      rd_wait <= '0;
    end else begin
      if (rd_strobe) begin
        rd_data <= next_data;
        rd_wait <= tm ? WAIT_W'(TM_EXTRA) : '0;
      end else if (rd_wait != '0) begin
        rd_wait <= rd_wait - 1'b1;
      end
      if (wr_strobe)      rd_live <= 1'b0;
      else if (rd_strobe) rd_live <= 1'b1;
      else if (cas_n)     rd_live <= 1'b0;
    end
  end

  p_early_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !dq_oe);

  p_tm_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && tm) |=> !dq_oe);

  p_normal_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !tm) |=> (dq_oe || oe_n));

  p_quiet_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

endmodule

// File: rtl/dram_ptest_core.sv
module dram_ptest_core #(
  parameter int ADDR_W   = 3,
  parameter int DW       = 4,
  parameter int TM_EXTRA = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  output logic              testmode_active
);

  logic [ADDR_W-1:0] row_addr;
  logic              wr_strobe, rd_strobe;
  logic              tm_set, tm_clr_cbr, tm_clr_rowonly;
  logic              tm_q;
  logic [DW-1:0]     rd_even, rd_odd;

  dtm_strobe_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk            (clk),
    .rst_n          (rst_n),
    .ras_n          (ras_n),
    .cas_n          (cas_n),
    .we_n           (we_n),
    .addr           (addr),
    .row_addr       (row_addr),
    .wr_strobe      (wr_strobe),
    .rd_strobe      (rd_strobe),
    .tm_set         (tm_set),
    .tm_clr_cbr     (tm_clr_cbr),
    .tm_clr_rowonly (tm_clr_rowonly)
  );

  dtm_mode_latch u_mode (
    .clk            (clk),
    .rst_n          (rst_n),
    .tm_set         (tm_set),
    .tm_clr_cbr     (tm_clr_cbr),
    .tm_clr_rowonly (tm_clr_rowonly),
    .tm_q           (tm_q)
  );

  dtm_array #(.ADDR_W(ADDR_W), .DW(DW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .row     (row_addr),
    .col     (addr),
    .wr_en   (wr_strobe),
    .wr_both (tm_q),
    .wdata   (dq_in),
    .rd_even (rd_even),
    .rd_odd  (rd_odd)
  );

  dtm_read_path #(.DW(DW), .TM_EXTRA(TM_EXTRA)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .cas_n     (cas_n),
    .oe_n      (oe_n),
    .tm        (tm_q),
    .col_lsb   (addr[0]),
    .rd_even   (rd_even),
    .rd_odd    (rd_odd),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  assign testmode_active = tm_q;

  // R1: nothing is driven during reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!testmode_active && !dq_oe));

endmodule

// File: tb/sim_dram_ptest_core.sv
module sim_dram_ptest_core;

  localparam int ADDR_W = 3;
  localparam int DW     = 4;
  localparam int NCOL   = 1 << ADDR_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, ras_n, cas_n, we_n, oe_n;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     dq_in, dq_out;
  logic              dq_oe, testmode_active;

  dram_ptest_core #(.ADDR_W(ADDR_W), .DW(DW), .TM_EXTRA(1)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .testmode_active(testmode_active)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DW-1:0] exp_mem [NCOL*NCOL];
  bit exp_tm;
  int cur_row;

  function automatic int widx(input int r, input int c);
    return r * NCOL + c;
  endfunction

  function automatic logic [DW-1:0] pair_flags(input int r, input int c);
    int base = c - (c % 2);
    return ~(exp_mem[widx(r, base)] ^ exp_mem[widx(r, base + 1)]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic open_row(input int r);
    @(negedge clk);
    ras_n = 0; addr = ADDR_W'(r); cur_row = r;
  endtask

  task automatic close_row();
    @(negedge clk);
    ras_n = 1;
    @(negedge clk);
    chk("R10/R2 idle after row close dq_oe", dq_oe, 0);
  endtask

  task automatic page_write(input int c, input logic [DW-1:0] d);
    @(negedge clk);
    cas_n = 0; we_n = 0; addr = ADDR_W'(c); dq_in = d;
    @(negedge clk);
    cas_n = 1; we_n = 1;
    chk("R10 early write dq_oe", dq_oe, 0);
    if (exp_tm) begin
      exp_mem[widx(cur_row, c - (c % 2))]     = d;
      exp_mem[widx(cur_row, c - (c % 2) + 1)] = d;
    end else begin
      exp_mem[widx(cur_row, c)] = d;
    end
  endtask

  task automatic page_read(input int c, input bit try_oe);
    logic [DW-1:0] e;
    e = exp_tm ? pair_flags(cur_row, c) : exp_mem[widx(cur_row, c)];
    @(negedge clk);
    cas_n = 0; we_n = 1; addr = ADDR_W'(c);
    @(negedge clk);
    if (exp_tm) begin
      chk("R9 test read not yet valid", dq_oe, 0);
      @(negedge clk);
    end
    chk("R2/R9 dq_oe on read", dq_oe, 1);
    chk(exp_tm ? "R8 agreement flags" : "R2 read data", dq_out, e);
    if (try_oe) begin
      oe_n = 1; #1;
      chk("R12 oe_n high dq_oe", dq_oe, 0);
      chk("R12 oe_n high dq_out", dq_out, 0);
      oe_n = 0; #1;
      chk("R12 oe_n low again data", dq_out, e);
    end
    cas_n = 1;
  endtask

  task automatic cbr(input bit we_low);
    @(negedge clk);
    cas_n = 0; we_n = ~we_low; dq_in = 4'hF;
    @(negedge clk);
    ras_n = 0;
    @(negedge clk);
    ras_n = 1; cas_n = 1; we_n = 1;
    @(negedge clk);
    exp_tm = we_low;
    chk(we_low ? "R3 entry" : "R5 exit by refresh", testmode_active, {31'd0, we_low});
  endtask

  task automatic row_only(input int r);
    @(negedge clk);
    ras_n = 0; addr = ADDR_W'(r);
    @(negedge clk);
    @(negedge clk);
    ras_n = 1;
    @(negedge clk);
    exp_tm = 0;
    chk("R6 exit by row-only refresh", testmode_active, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NCOL*NCOL; i++) exp_mem[i] = '0;
    exp_tm = 0; cur_row = 0;
    rst_n = 0; ras_n = 1; cas_n = 1; we_n = 1; oe_n = 0; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset testmode_active", testmode_active, 0);
    chk("R1 reset dq_oe", dq_oe, 0);
    chk("R1 reset dq_out", dq_out, 0);
    open_row(5); page_read(3, 0); close_row();

    // normal page burst: R2, R11, R12
    open_row(2);
    page_write(4, 4'hA);
    page_write(5, 4'h5);
    page_read(4, 1);
    page_read(5, 0);
    close_row();
    chk("R4 still normal", testmode_active, 0);

    // test mode entry and compare: R3, R8, R9
    cbr(1);
    open_row(2);
    page_read(4, 0);
    page_read(5, 0);
    page_write(7, 4'h9);
    page_read(6, 0);
    close_row();
    chk("R4 mode held across row cycle", testmode_active, 1);

    // exit by refresh and verify pair write: R5, R7
    cbr(0);
    open_row(2);
    page_read(6, 0);
    page_read(7, 0);
    page_read(4, 0);
    close_row();

    // exit by row-only refresh: R6
    cbr(1);
    row_only(1);
    open_row(2);
    page_read(7, 0);
    close_row();

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int sel = $urandom_range(0, 11);
      if (sel == 0)      cbr(1);
      else if (sel == 1) cbr(0);
      else if (sel == 2) row_only($urandom_range(0, NCOL - 1));
      else begin
        open_row($urandom_range(0, NCOL - 1));
        for (int k = 0; k < $urandom_range(1, 4); k++) begin
          int c = $urandom_range(0, NCOL - 1);
          if ($urandom_range(0, 1) == 1) page_write(c, DW'($urandom));
          else page_read(c, $urandom_range(0, 7) == 0);
        end
        close_row();
        chk("R4/R11 mode after random row", testmode_active, {31'd0, exp_tm});
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule